// File: doc/BRIEF.md
# Framebuffer Control and Vertical-Sync Interrupt Register Block

This block is the control and status corner of a framebuffer controller. It sits on a byte-wide register window of 32 addresses. The upper half of the window holds four things. The first is a control byte whose top bit gates the vertical-sync interrupt. The second is a status byte that reports fixed board identity alongside a sticky interrupt-pending flag. The rest are fourteen general byte registers that software uses for cursor and video-control settings. The lower half of the window belongs to the colour palette, which another block decodes, so here it reads as zero and ignores writes.

The display timing logic pulses `frame_end` once per frame. If interrupts are enabled when the pulse arrives, the pending flag is set and `irq` rises as a level. Software acknowledges the interrupt by writing anything to the status byte. Read data is registered: it appears one clock after the read strobe and holds until the next read.

Top module: `fbc_frame_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the control byte, the pending flag, all fourteen storage bytes and `bus_rdata`, and drives `irq` low.
- R2: Offset 0x10 is the control byte. All 8 bits can be written and read back, and bit 7 is the interrupt enable.
- R3: A read of offset 0x11 returns 0xE1 when the pending flag is set and 0x61 when it is clear. The pending flag is bit 7, and bits 6..0 are fixed at 0x61 whatever is written.
- R4: A `frame_end` pulse sampled while control bit 7 is 1 sets the pending flag and `irq` at that clock edge. A pulse sampled while bit 7 is 0 changes nothing.
- R5: Any write to offset 0x11 clears the pending flag and `irq` at that clock edge, whatever the data.
- R6: When `frame_end` (with enable set) and a status write are sampled on the same edge, the pending flag ends up set.
- R7: Offsets 0x12..0x1F are independent read/write bytes. A write to one leaves the others unchanged.
- R8: Offsets 0x00..0x0F read as 0x00, and writes to them change no state.
- R9: `bus_rdata` is loaded at the edge where `bus_rd` is sampled, with the value held before that edge. If a write to the same offset comes in the same cycle, the old value is returned. Without `bus_rd`, `bus_rdata` holds.
- R10: The pending flag is sticky. Clearing the enable bit or further `frame_end` pulses do not clear it; only a status write or reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_rd | input | 1 | Read strobe for the register window |
| bus_addr | input | 5 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| frame_end | input | 1 | One-cycle end-of-frame pulse from display timing |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
Every result of this block is due exactly one clock edge after its stimulus is sampled. Reads, control and storage writes, the pending-flag set from `frame_end`, and its clear from a status write all register once, with no further pipeline stage. The bench changes inputs on the falling edge and samples `bus_rdata` and `irq` on the following falling edge, which is half a period after the one rising edge that must reflect the stimulus. Cases that hinge on same-edge ordering (pulse against acknowledge, read against write to one offset) are placed in a single vector so that the one edge decides them.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int FBC_ADDR_W    = 5;
    localparam int FBC_DATA_W    = 8;
    localparam int FBC_SLOTS     = 16;   // upper half of the window
    localparam int FBC_IDX_W     = $clog2(FBC_SLOTS);
    localparam int FBC_STORE_LO  = 2;    // first general-purpose slot
    localparam int FBC_IRQ_EN_B  = 7;    // enable bit in the control byte
    localparam int FBC_PEND_B    = 7;    // pending bit in the status byte

    // Fixed identity bits merged into every status read.
    localparam logic [FBC_DATA_W-1:0] FBC_STAT_ID = 8'h61;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_STORE
    } fbc_sel_e;

    typedef struct packed {
        fbc_sel_e               sel;
        logic [FBC_IDX_W-1:0]   idx;
    } fbc_dec_t;

    function automatic fbc_dec_t fbc_decode(input logic [FBC_ADDR_W-1:0] a);
        fbc_dec_t d;
        d.idx = a[FBC_IDX_W-1:0];
        if (!a[FBC_ADDR_W-1]) begin
            d.sel = SEL_NONE;
        end else if (a[FBC_IDX_W-1:0] == FBC_IDX_W'(0)) begin
            d.sel = SEL_CTRL;
        end else if (a[FBC_IDX_W-1:0] == FBC_IDX_W'(1)) begin
            d.sel = SEL_STAT;
        end else begin
            d.sel = SEL_STORE;
        end
        return d;
    endfunction

    function automatic logic [FBC_DATA_W-1:0] fbc_status_byte(input logic pend);
        logic [FBC_DATA_W-1:0] s;
        s = FBC_STAT_ID;
        s[FBC_PEND_B] = pend;
        return s;
    endfunction

endpackage

// File: rtl/fbc_addr_decode.sv
module fbc_addr_decode
    import fbc_pkg::*;
#(
    parameter int ADDR_W = FBC_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output fbc_dec_t          dec
);
    always_comb begin
        dec = fbc_decode(addr);
    end
endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic irq_en,
    input  logic stat_wr,
    output logic pending
);
    logic set_evt;
    assign set_evt = frame_end && irq_en;

    // Set has priority over the acknowledge.
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set_evt) begin
            pending <= 1'b1;
        end else if (stat_wr) begin
            pending <= 1'b0;
        end
    end

    a_r4_set: assert property (@(posedge clk) disable iff (rst)
        (frame_end && irq_en) |=> pending);
    a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(frame_end && irq_en)) |=> !pending);
    a_r5_ack: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !(frame_end && irq_en)) |=> !pending);
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (pending && !stat_wr) |=> pending);
endmodule

// File: rtl/fbc_store_bank.sv
module fbc_store_bank
    import fbc_pkg::*;
#(
    parameter int SLOTS  = FBC_SLOTS,
    parameter int LO     = FBC_STORE_LO,
    parameter int DATA_W = FBC_DATA_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i >= LO) begin : g_reg
            logic hit;
            assign hit = wr_en && (wr_idx == IDX_W'(i));
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[i] <= '0;
                end else if (hit) begin
                    slot_q[i] <= wr_data;
                end
            end
            a_r7_keep: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && (wr_idx == IDX_W'(i))) |=> $stable(slot_q[i]));
        end else begin : g_tie
            assign slot_q[i] = '0;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/fbc_frame_ctrl.sv
module fbc_frame_ctrl
    import fbc_pkg::*;
#(
    parameter int ADDR_W = FBC_ADDR_W,
    parameter int DATA_W = FBC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_end,
    output logic              irq
);
    fbc_dec_t          dec;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] store_rd;
    logic [DATA_W-1:0] rd_mux;
    logic              pending;
    logic              ctrl_wr, stat_wr, store_wr;

    fbc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign ctrl_wr  = bus_wr && (dec.sel == SEL_CTRL);
    assign stat_wr  = bus_wr && (dec.sel == SEL_STAT);
    assign store_wr = bus_wr && (dec.sel == SEL_STORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata;
        end
    end

    fbc_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .irq_en    (ctrl_q[FBC_IRQ_EN_B]),
        .stat_wr   (stat_wr),
        .pending   (pending)
    );

    fbc_store_bank #(
        .SLOTS  (FBC_SLOTS),
        .LO     (FBC_STORE_LO),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_wr),
        .wr_idx  (dec.idx),
        .wr_data (bus_wdata),
        .rd_idx  (dec.idx),
        .rd_data (store_rd)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_CTRL:  rd_mux = ctrl_q;
            SEL_STAT:  rd_mux = fbc_status_byte(pending);
            SEL_STORE: rd_mux = store_rd;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign irq = pending;

    a_r3_id_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(17)) |=> (bus_rdata[6:0] == 7'h61));
    a_r8_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr[ADDR_W-1]) |=> (bus_rdata == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
    a_r2_ctrl_keep: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == ADDR_W'(16)) |=> $stable(ctrl_q));
endmodule

// File: tb/fbc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module fbc_frame_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, frame_end = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fbc_frame_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_end(frame_end), .irq(irq)
    );

    // Vector: req(4) wr rd addr(5) wdata(8) fe chk_rd exp_rd(8) exp_irq
    localparam int VW = 30;
    localparam int NV = 27;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2, 1'b1,1'b0,5'h10,8'h80,1'b0, 1'b0,8'h00,1'b0}, // R2 enable
        {4'd2, 1'b0,1'b1,5'h10,8'h00,1'b0, 1'b1,8'h80,1'b0}, // R2 readback
        {4'd3, 1'b0,1'b1,5'h11,8'h00,1'b0, 1'b1,8'h61,1'b0}, // R3 idle status
        {4'd4, 1'b0,1'b0,5'h00,8'h00,1'b1, 1'b0,8'h00,1'b1}, // R4 set
        {4'd3, 1'b0,1'b1,5'h11,8'h00,1'b0, 1'b1,8'hE1,1'b1}, // R3 pending
        {4'd5, 1'b1,1'b0,5'h11,8'h00,1'b0, 1'b0,8'h00,1'b0}, // R5 ack 0x00
        {4'd4, 1'b0,1'b0,5'h00,8'h00,1'b1, 1'b0,8'h00,1'b1}, // R4 set again
        {4'd5, 1'b1,1'b0,5'h11,8'hFF,1'b0, 1'b0,8'h00,1'b0}, // R5 ack 0xFF
        {4'd6, 1'b1,1'b0,5'h11,8'h00,1'b1, 1'b0,8'h00,1'b1}, // R6 collision
        {4'd10,1'b1,1'b0,5'h10,8'h00,1'b0, 1'b0,8'h00,1'b1}, // R10 disable
        {4'd10,1'b0,1'b0,5'h00,8'h00,1'b1, 1'b0,8'h00,1'b1}, // R10 pulse
        {4'd5, 1'b1,1'b0,5'h11,8'h5A,1'b0, 1'b0,8'h00,1'b0}, // R5 ack 0x5A
        {4'd4, 1'b0,1'b0,5'h00,8'h00,1'b1, 1'b0,8'h00,1'b0}, // R4 disabled
        {4'd7, 1'b1,1'b0,5'h12,8'hA5,1'b0, 1'b0,8'h00,1'b0}, // R7 write
        {4'd7, 1'b1,1'b0,5'h1F,8'h3C,1'b0, 1'b0,8'h00,1'b0}, // R7 write
        {4'd8, 1'b1,1'b0,5'h05,8'hFF,1'b0, 1'b0,8'h00,1'b0}, // R8 hole wr
        {4'd7, 1'b0,1'b1,5'h12,8'h00,1'b0, 1'b1,8'hA5,1'b0}, // R7 read
        {4'd7, 1'b0,1'b1,5'h1F,8'h00,1'b0, 1'b1,8'h3C,1'b0}, // R7 read
        {4'd8, 1'b0,1'b1,5'h05,8'h00,1'b0, 1'b1,8'h00,1'b0}, // R8 hole rd
        {4'd7, 1'b0,1'b1,5'h13,8'h00,1'b0, 1'b1,8'h00,1'b0}, // R7 untouched
        {4'd7, 1'b0,1'b1,5'h12,8'h00,1'b0, 1'b1,8'hA5,1'b0}, // R7 read
        {4'd9, 1'b0,1'b0,5'h00,8'h00,1'b0, 1'b1,8'hA5,1'b0}, // R9 hold
        {4'd2, 1'b1,1'b0,5'h10,8'h7F,1'b0, 1'b0,8'h00,1'b0}, // R2 low bits
        {4'd2, 1'b0,1'b1,5'h10,8'h00,1'b0, 1'b1,8'h7F,1'b0}, // R2 readback
        {4'd4, 1'b0,1'b0,5'h00,8'h00,1'b1, 1'b0,8'h00,1'b0}, // R4 bit7 clear
        {4'd3, 1'b1,1'b0,5'h11,8'h1E,1'b0, 1'b0,8'h00,1'b0}, // R3 wr status
        {4'd3, 1'b0,1'b1,5'h11,8'h00,1'b0, 1'b1,8'h61,1'b0}  // R3 id fixed
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic [4:0] a,
                         input logic [7:0] d, input logic fe);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; frame_end = fe;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; frame_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "rdata after reset", bus_rdata, 8'h00);
        check("R1", "irq after reset", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[29:26]);
            drive(v[25], v[24], v[23:19], v[18:11], v[10]);
            if (v[9]) check(tag, $sformatf("vec %0d rdata", i), bus_rdata, v[8:1]);
            check(tag, $sformatf("vec %0d irq", i), {7'b0, irq}, {7'b0, v[0]});
        end

        // R9: read and write to the same slot in one cycle returns the old byte
        drive(1'b1, 1'b1, 5'h14, 8'h11, 1'b0);
        check("R9", "read during write", bus_rdata, 8'h00);
        drive(1'b0, 1'b1, 5'h14, 8'h00, 1'b0);
        check("R9", "read after write", bus_rdata, 8'h11);

        // R1: reset in mid-operation clears everything
        drive(1'b1, 1'b0, 5'h10, 8'h80, 1'b0);
        drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
        check("R4", "irq before reset", {7'b0, irq}, 8'h01);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "irq cleared", {7'b0, irq}, 8'h00);
        check("R1", "rdata cleared", bus_rdata, 8'h00);
        drive(1'b0, 1'b1, 5'h10, 8'h00, 1'b0);
        check("R1", "ctrl cleared", bus_rdata, 8'h00);
        drive(1'b0, 1'b1, 5'h11, 8'h00, 1'b0);
        check("R1", "pending cleared", bus_rdata, 8'h61);
        drive(1'b0, 1'b1, 5'h12, 8'h00, 1'b0);
        check("R1", "slot 0x12 cleared", bus_rdata, 8'h00);
        drive(1'b0, 1'b1, 5'h14, 8'h00, 1'b0);
        check("R1", "slot 0x14 cleared", bus_rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule